// File: doc/BRIEF.md
# Wake and Power-Event Flag Register

This block holds a small set of sticky event flags that tell the processor why it woke up or why it was interrupted. It watches a push-button level and a PLL-lock level for edges. It also takes single-cycle event strobes from the auto-wake timer, from the data-transfer engine and from the one-second real-time tick. Each event sets its own flag, and the flag stays set until firmware clears it. Firmware clears a flag by writing a 0 to that bit. A 1 written to a bit leaves that bit as it was.

Some clears happen without firmware. A request to enter sleep or LCD-only mode clears the push-button flag. The PLL-fall flag is not raised when the current wake into brownout was caused by the push-button or the wake timer. The block also drives two interrupt lines from its flags. Through the same read port, firmware can read the raw, unstored levels of the seven external interrupt inputs.

Every input is taken to be synchronous to `clk`. Power-mode sequencing is handled elsewhere.

Top module: `wake_evt_flags`

## Requirements
- R1: A rising edge on `btn_i` (low in one cycle, high in the next) sets flag bit 0 on the clock edge that samples the high level.
- R2: A write (`wr_en_i` high) clears each flag bit whose `wr_data_i` bit is 0 and leaves unchanged each flag bit whose `wr_data_i` bit is 1.
- R3: A cycle with `sleep_req_i` or `lcd_req_i` high clears flag bit 0 and no other flag.
- R4: A rising edge on `pll_lock_i` sets flag bit 1.
- R5: A falling edge on `pll_lock_i` sets flag bit 2, except when `wake_src_i` is high in that cycle, in which case bit 2 is left unchanged.
- R6: A cycle with `autowake_i` high sets flag bit 3.
- R7: `xfer_busy_i` high sets flag bit 4 and `rtc_sec_i` high sets flag bit 5. `irq6_o` is high exactly while bit 4 or bit 5 is set.
- R8: `irq_pwr_o` is high exactly while flag bit 1 or bit 2 is set.
- R9: When a set event and a clear (from a write or from a mode request) hit the same bit in the same cycle, the bit ends up set.
- R10: `rd_data_o` is combinational. With `rd_sel_i` at 0 it returns the flags, bits 7:6 reading 0. With `rd_sel_i` at 1 it returns `{1'b0, ext_int_i}`.
- R11: Synchronous reset clears all flags. The edge history follows the inputs during reset, so a level that is held high through reset release produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Push-button level |
| pll_lock_i | input | 1 | PLL-lock level |
| autowake_i | input | 1 | Auto-wake timer event strobe |
| xfer_busy_i | input | 1 | Transfer-busy event strobe |
| rtc_sec_i | input | 1 | One-second tick strobe |
| sleep_req_i | input | 1 | Sleep-mode request |
| lcd_req_i | input | 1 | LCD-only-mode request |
| wake_src_i | input | 1 | Current brownout wake came from the push-button or the wake timer |
| ext_int_i | input | 7 | Raw external interrupt levels 0..6 |
| wr_en_i | input | 1 | Flag write strobe |
| wr_data_i | input | 8 | Write data; a 0 clears the matching flag |
| rd_sel_i | input | 1 | Read select: 0 returns the flags, 1 returns the raw interrupt levels |
| rd_data_o | output | 8 | Read data |
| irq6_o | output | 1 | Transfer or RTC interrupt |
| irq_pwr_o | output | 1 | Power-event interrupt |

## Verification
The edge detectors are driven three ways: with a held-high level, which must not re-trigger, with a fresh rise, and with PLL falls both with and without the wake-source qualifier. This separates true edge detection from level sensing and shows that the suppression applies only to the fall flag. Clear writes are issued with all-ones data, with masks that clear one bit or two bits, and at the same moment as a set or a mode request. Those patterns show per-bit clearing, the set-over-clear priority, and that a mode request affects only the push-button flag. Reset is applied with the inputs held high to show that no edge is seen on release.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    localparam int DATA_W = 8;
    localparam int FLAG_N = 6;

    localparam int F_BTN   = 0;
    localparam int F_PLLR  = 1;
    localparam int F_PLLF  = 2;
    localparam int F_AWAKE = 3;
    localparam int F_XFER  = 4;
    localparam int F_RTC   = 5;

    // index of each watched level inside the edge detector
    localparam int LV_BTN = 0;
    localparam int LV_PLL = 1;
    localparam int LV_N   = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic btn_rise;
        logic pll_rise;
        logic pll_fall;
    } edges_t;

    // bits that a firmware write clears
    function automatic word_t write_clear(input logic wr_en, input word_t wr_data);
        return wr_en ? ~wr_data : '0;
    endfunction

endpackage

// File: rtl/wkf_edge.sv
module wkf_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // history tracks the input even in reset: no edge on release
        always_ff @(posedge clk) begin
            prev_q[i] <= lvl_i[i];
        end
        assign rise_o[i] = lvl_i[i] & ~prev_q[i] & ~rst;
        assign fall_o[i] = ~lvl_i[i] & prev_q[i] & ~rst;
    end
endmodule

// File: rtl/wkf_flag_bank.sv
module wkf_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)           flags_o[i] <= 1'b0;
            else if (set_i[i]) flags_o[i] <= 1'b1;
            else if (clr_i[i]) flags_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/wkf_read_mux.sv
module wkf_read_mux
    import wkf_pkg::*;
#(
    parameter int EXT_N = 7
) (
    input  logic             rd_sel_i,
    input  word_t            flags_i,
    input  logic [EXT_N-1:0] ext_i,
    output word_t            rd_data_o
);
    localparam int PAD = DATA_W - EXT_N;

    word_t raw_w;
    assign raw_w     = {{PAD{1'b0}}, ext_i};
    assign rd_data_o = rd_sel_i ? raw_w : flags_i;
endmodule

// File: rtl/wake_evt_flags.sv
module wake_evt_flags
    import wkf_pkg::*;
#(
    parameter int EXT_INT_N = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 btn_i,
    input  logic                 pll_lock_i,
    input  logic                 autowake_i,
    input  logic                 xfer_busy_i,
    input  logic                 rtc_sec_i,
    input  logic                 sleep_req_i,
    input  logic                 lcd_req_i,
    input  logic                 wake_src_i,
    input  logic [EXT_INT_N-1:0] ext_int_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 rd_sel_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 irq6_o,
    output logic                 irq_pwr_o
);
    logic [LV_N-1:0] lvl_w, rise_w, fall_w;
    edges_t          edg;
    word_t           set_w, clr_w, flags_q;

    assign lvl_w[LV_BTN] = btn_i;
    assign lvl_w[LV_PLL] = pll_lock_i;

    wkf_edge #(.N(LV_N)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    assign edg.btn_rise = rise_w[LV_BTN];
    assign edg.pll_rise = rise_w[LV_PLL];
    assign edg.pll_fall = fall_w[LV_PLL];

    always_comb begin
        set_w          = '0;
        set_w[F_BTN]   = edg.btn_rise;
        set_w[F_PLLR]  = edg.pll_rise;
        set_w[F_PLLF]  = edg.pll_fall & ~wake_src_i;
        set_w[F_AWAKE] = autowake_i;
        set_w[F_XFER]  = xfer_busy_i;
        set_w[F_RTC]   = rtc_sec_i;

        clr_w          = write_clear(wr_en_i, wr_data_i);
        clr_w[F_BTN]   = clr_w[F_BTN] | sleep_req_i | lcd_req_i;
    end

    wkf_flag_bank #(.N(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_w),
        .clr_i   (clr_w),
        .flags_o (flags_q)
    );

    wkf_read_mux #(.EXT_N(EXT_INT_N)) u_rd (
        .rd_sel_i  (rd_sel_i),
        .flags_i   (flags_q),
        .ext_i     (ext_int_i),
        .rd_data_o (rd_data_o)
    );

    assign irq6_o    = flags_q[F_XFER] | flags_q[F_RTC];
    assign irq_pwr_o = flags_q[F_PLLR] | flags_q[F_PLLF];
endmodule

// File: rtl/wake_evt_flags_chk.sv
module wake_evt_flags_chk
    import wkf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        btn_i,
    input logic        pll_lock_i,
    input logic        autowake_i,
    input logic        xfer_busy_i,
    input logic        sleep_req_i,
    input logic        lcd_req_i,
    input logic        wake_src_i,
    input logic        wr_en_i,
    input logic [7:0]  wr_data_i,
    input logic [7:0]  flags_q,
    input logic        irq6_o,
    input logic        irq_pwr_o
);
    logic btn_h, pll_h, live;
    always_ff @(posedge clk) begin
        btn_h <= btn_i;
        pll_h <= pll_lock_i;
        live  <= ~rst;
    end

    // R1
    btn_rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (live && btn_i && !btn_h) |=> flags_q[F_BTN]);

    // R2
    wr_zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_data_i[F_AWAKE] && !autowake_i) |=> !flags_q[F_AWAKE]);

    // R3
    mode_req_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (live && (sleep_req_i || lcd_req_i) && !(btn_i && !btn_h)) |=> !flags_q[F_BTN]);

    // R5
    fall_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !pll_lock_i && pll_h && wake_src_i && !flags_q[F_PLLF]) |=> !flags_q[F_PLLF]);

    // R7
    xfer_irq_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_busy_i |=> irq6_o);

    // R8
    pwr_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (live && pll_lock_i && !pll_h) |=> irq_pwr_o);

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (autowake_i && wr_en_i) |=> flags_q[F_AWAKE]);
endmodule

bind wake_evt_flags wake_evt_flags_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .btn_i       (btn_i),
    .pll_lock_i  (pll_lock_i),
    .autowake_i  (autowake_i),
    .xfer_busy_i (xfer_busy_i),
    .sleep_req_i (sleep_req_i),
    .lcd_req_i   (lcd_req_i),
    .wake_src_i  (wake_src_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .flags_q     (flags_q),
    .irq6_o      (irq6_o),
    .irq_pwr_o   (irq_pwr_o)
);

// File: tb/wake_evt_flags_tb.sv
module wake_evt_flags_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_i = 0, pll_lock_i = 0, autowake_i = 0, xfer_busy_i = 0, rtc_sec_i = 0;
    logic sleep_req_i = 0, lcd_req_i = 0, wake_src_i = 0;
    logic [6:0] ext_int_i = '0;
    logic wr_en_i = 0;
    logic [7:0] wr_data_i = '0;
    logic rd_sel_i = 0;
    logic [7:0] rd_data_o;
    logic irq6_o, irq_pwr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wake_evt_flags u_dut (
        .clk(clk), .rst(rst), .btn_i(btn_i), .pll_lock_i(pll_lock_i),
        .autowake_i(autowake_i), .xfer_busy_i(xfer_busy_i), .rtc_sec_i(rtc_sec_i),
        .sleep_req_i(sleep_req_i), .lcd_req_i(lcd_req_i), .wake_src_i(wake_src_i),
        .ext_int_i(ext_int_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq6_o(irq6_o), .irq_pwr_o(irq_pwr_o)
    );

    // ins = {btn, pll, autowake, xfer, rtc, sleep, lcd, wake_src}
    typedef struct packed {
        logic [7:0] ins;
        logic       wr;
        logic [7:0] wd;
        logic [5:0] ef;
        logic       i6;
        logic       ip;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{8'b00000000, 1'b0, 8'h00, 6'b000000, 1'b0, 1'b0}, // idle
        '{8'b10000000, 1'b0, 8'h00, 6'b000001, 1'b0, 1'b0}, // R1 rise
        '{8'b10000000, 1'b0, 8'h00, 6'b000001, 1'b0, 1'b0}, // R1 held, no retrigger
        '{8'b00000000, 1'b1, 8'hFF, 6'b000001, 1'b0, 1'b0}, // R2 ones keep
        '{8'b00000000, 1'b1, 8'hFE, 6'b000000, 1'b0, 1'b0}, // R2 zero clears
        '{8'b10000000, 1'b1, 8'h00, 6'b000001, 1'b0, 1'b0}, // R9 set beats write
        '{8'b10000100, 1'b0, 8'h00, 6'b000000, 1'b0, 1'b0}, // R3 sleep clears
        '{8'b00000000, 1'b0, 8'h00, 6'b000000, 1'b0, 1'b0},
        '{8'b10000010, 1'b0, 8'h00, 6'b000001, 1'b0, 1'b0}, // R9 set beats lcd
        '{8'b10000010, 1'b0, 8'h00, 6'b000000, 1'b0, 1'b0}, // R3 lcd clears
        '{8'b11000000, 1'b0, 8'h00, 6'b000010, 1'b0, 1'b1}, // R4 R8
        '{8'b10000000, 1'b0, 8'h00, 6'b000110, 1'b0, 1'b1}, // R5 fall
        '{8'b10000000, 1'b1, 8'hF9, 6'b000000, 1'b0, 1'b0}, // R2 two bits
        '{8'b11000000, 1'b0, 8'h00, 6'b000010, 1'b0, 1'b1}, // R4
        '{8'b10000001, 1'b0, 8'h00, 6'b000010, 1'b0, 1'b1}, // R5 suppressed
        '{8'b10000000, 1'b1, 8'hFD, 6'b000000, 1'b0, 1'b0}, // R8 low
        '{8'b10100000, 1'b0, 8'h00, 6'b001000, 1'b0, 1'b0}, // R6
        '{8'b10010000, 1'b0, 8'h00, 6'b011000, 1'b1, 1'b0}, // R7 xfer
        '{8'b10001000, 1'b0, 8'h00, 6'b111000, 1'b1, 1'b0}, // R7 rtc
        '{8'b10000000, 1'b1, 8'hEF, 6'b101000, 1'b1, 1'b0}, // R7 one left
        '{8'b10000000, 1'b1, 8'hD7, 6'b000000, 1'b0, 1'b0}, // R7 both clear
        '{8'b10100100, 1'b0, 8'h00, 6'b001000, 1'b0, 1'b0}, // R3 only bit0
        '{8'b10000000, 1'b1, 8'h00, 6'b000000, 1'b0, 1'b0}  // R2 all clear
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: levels high through reset release give no edge
        btn_i = 1; pll_lock_i = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        tick();
        check8("R11 reset no edge", rd_data_o, 8'h00);
        check8("R11 irq idle", {6'b0, irq6_o, irq_pwr_o}, 8'h00);
        // re-enter reset and bring levels low
        rst = 1; btn_i = 0; pll_lock_i = 0;
        repeat (2) tick();
        rst = 0;
        tick();

        for (int i = 0; i < NV; i++) begin
            {btn_i, pll_lock_i, autowake_i, xfer_busy_i, rtc_sec_i,
             sleep_req_i, lcd_req_i, wake_src_i} = VEC[i].ins;
            wr_en_i = VEC[i].wr;
            wr_data_i = VEC[i].wd;
            tick();
            check8($sformatf("R1-R9 vector %0d flags", i), rd_data_o, {2'b00, VEC[i].ef});
            check8($sformatf("R7/R8 vector %0d irqs", i), {6'b0, irq6_o, irq_pwr_o},
                   {6'b0, VEC[i].i6, VEC[i].ip});
        end
        {btn_i, pll_lock_i, autowake_i, xfer_busy_i, rtc_sec_i,
         sleep_req_i, lcd_req_i, wake_src_i} = '0;
        wr_en_i = 0;
        tick();

        // R10: raw interrupt levels, combinational
        ext_int_i = 7'h55; rd_sel_i = 1;
        #1;
        check8("R10 raw read", rd_data_o, 8'h55);
        ext_int_i = 7'h7F;
        #1;
        check8("R10 raw upper bit zero", rd_data_o, 8'h7F);
        rd_sel_i = 0; ext_int_i = '0;

        // R11: reset clears set flags
        autowake_i = 1; xfer_busy_i = 1;
        tick();
        autowake_i = 0; xfer_busy_i = 0;
        check8("R11 before reset", rd_data_o, 8'h18);
        rst = 1;
        tick();
        rst = 0;
        check8("R11 after reset", rd_data_o, 8'h00);
        check8("R11 irq after reset", {6'b0, irq6_o, irq_pwr_o}, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule